// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a register-mapped coprocessor that transforms one 8x8 block of signed samples into 64 two-dimensional forward DCT coefficients using integer fixed-point arithmetic. A host loads the block one sample at a time through a data-in register and starts the transform with a command write. It then polls a status register until the result is ready, and unloads the coefficients one at a time through a data-out register.

Inside, a single multiply-accumulate datapath walks all 4096 (output, input) pairs in sequence, one term per clock. Cosine factors come from a 64-entry table of signed values with 6 fractional bits. That table is derived at elaboration from eight stored magnitudes and the symmetry of the cosine. The two normalisation factors for frequency index zero and the final divide by four are applied when each coefficient is written to the result buffer.

Top module: `fdct_coproc`

## Requirements
- R1: The 2-bit address selects the register: 0 data-in (write), 1 data-out (read), 2 command (write), 3 status (read). Read data appears on `rdata` in the cycle after the clock edge that samples `rd_en`. Reads of addresses 0 and 2 return 0.
- R2: Each data-in write while idle stores the low 12 bits, as a signed sample, at the push position and advances it. Position p holds row x = p/8, column y = p%8 (row-major). The position wraps from 63 to 0, so a 65th write replaces sample 0.
- R3: A command write with bit 0 set, made while idle, starts a transform and returns the push and pop positions to 0. A command write with bit 0 clear, or any command write while busy, has no effect.
- R4: Status bit 0 is done and bit 1 is busy, and both read 0 after reset. Busy is set by the clock edge that accepts the command and stays set for exactly 4096 cycles. Done is set when busy clears and is cleared by the next accepted command. The two flags are never set together.
- R5: The cosine factor for sample position i and frequency f is round(64*cos((2i+1)*f*pi/16)), stored as an 8-bit signed value.
- R6: For each output (u,v), the unnormalised sum adds, over all x and y, the term ((D(x,y)*c(x,u)) >>> 6) * c(y,v) >>> 6. All shifts are arithmetic, and the sum is exact with no wrap for any 12-bit signed input.
- R7: The sum is then multiplied by 45 and shifted right arithmetically by 6 when u = 0, then the same again when v = 0, then shifted right arithmetically by 2. The result is returned as a 16-bit two's-complement value.
- R8: Each data-out read while idle returns coefficient (u,v) at pop position u*8+v and advances the position, which wraps from 63 to 0.
- R9: Data-in writes while busy are ignored. The input block is retained after a transform, so a new command with no new writes yields the same 64 coefficients.
- R10: A data-out read while busy returns 0 and does not advance the pop position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 12 | Write data: signed sample, or command in bit 0 |
| rdata | output | 16 | Registered read data: coefficient or status |

## Verification
The hardest situation to reach is host traffic that lands while the engine is busy. This includes a stray sample write, an early data-out read and a second start command, each of which must leave the running transform, the retained input block and the pop position untouched. The stimulus issues a start and then, within the busy window, writes samples, reads data-out and repeats the command. It then checks three things: that the busy window shrank by exactly the cycles those accesses used, that the early reads returned 0, and that the first coefficients popped afterwards match those of the untouched block.

// File: rtl/fdct_pkg.sv
package fdct_pkg;

  localparam int BLK_N     = 8;
  localparam int BLK_SZ    = BLK_N * BLK_N;
  localparam int RUN_CYC   = BLK_SZ * BLK_SZ;
  localparam int IDX_W     = $clog2(BLK_SZ);
  localparam int CNT_W     = $clog2(RUN_CYC);
  localparam int COS_W     = 8;
  localparam int COS_FRAC  = 6;
  localparam int POST_SHR  = 2;
  localparam logic signed [COS_W-1:0] INV_SQRT2_Q = 8'sd45;

  typedef enum logic [1:0] {
    REG_DIN  = 2'd0,
    REG_DOUT = 2'd1,
    REG_CMD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Magnitudes of round(64*cos(m*pi/16)) for m = 0..8
  function automatic int cos_mag(input int m);
    case (m)
      0:       return 64;
      1:       return 63;
      2:       return 59;
      3:       return 53;
      4:       return 45;
      5:       return 36;
      6:       return 24;
      7:       return 12;
      default: return 0;
    endcase
  endfunction

  // Fold the phase index into the first quarter period and restore the sign
  function automatic logic signed [COS_W-1:0] cos_q6(input int pos, input int freq);
    int k;
    int m;
    int val;
    k = ((2 * pos + 1) * freq) % 32;
    m = (k > 16) ? (32 - k) : k;
    if (m <= 8) val = cos_mag(m);
    else        val = -cos_mag(16 - m);
    return COS_W'(val);
  endfunction

endpackage

// File: rtl/fdct_costab.sv
module fdct_costab
  import fdct_pkg::*;
(
  input  logic [2:0]              pos_a,
  input  logic [2:0]              freq_a,
  input  logic [2:0]              pos_b,
  input  logic [2:0]              freq_b,
  output logic signed [COS_W-1:0] coef_a,
  output logic signed [COS_W-1:0] coef_b
);

  logic signed [COS_W-1:0] tab [BLK_SZ];

  for (genvar p = 0; p < BLK_N; p++) begin : g_pos
    for (genvar f = 0; f < BLK_N; f++) begin : g_frq
      assign tab[p*BLK_N + f] = cos_q6(p, f);
    end
  end

  assign coef_a = tab[{pos_a, freq_a}];
  assign coef_b = tab[{pos_b, freq_b}];

endmodule

// File: rtl/fdct_engine.sv
module fdct_engine
  import fdct_pkg::*;
#(
  parameter int SAMP_W = 12,
  parameter int OUT_W  = 16,
  parameter int ACC_W  = SAMP_W + 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [SAMP_W-1:0] sample,
  output logic [IDX_W-1:0]         smp_idx,
  output logic                     busy,
  output logic                     finish,
  output logic                     res_we,
  output logic [IDX_W-1:0]         res_idx,
  output logic signed [OUT_W-1:0]  res_val
);

  localparam int P1_W = SAMP_W + COS_W;
  localparam int P2_W = P1_W + COS_W;
  localparam int SC_W = ACC_W + COS_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_SZ - 1);

  logic                    busy_q, busy_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  logic [2:0] u_f, v_f, x_p, y_p;
  logic signed [COS_W-1:0] cx, cy;
  logic signed [P1_W-1:0]  p1, s1;
  logic signed [P2_W-1:0]  p2, s2;
  logic signed [ACC_W-1:0] term, acc_sum;
  logic signed [SC_W-1:0]  sc0, sc1, sc2;
  logic                    inner_first, inner_last, run_last;

  assign u_f = cnt_q[11:9];
  assign v_f = cnt_q[8:6];
  assign x_p = cnt_q[5:3];
  assign y_p = cnt_q[2:0];

  fdct_costab u_costab (
    .pos_a  (x_p),
    .freq_a (u_f),
    .pos_b  (y_p),
    .freq_b (v_f),
    .coef_a (cx),
    .coef_b (cy)
  );

  assign inner_first = (cnt_q[IDX_W-1:0] == '0);
  assign inner_last  = (cnt_q[IDX_W-1:0] == IDX_LAST);
  assign run_last    = busy_q && (cnt_q == CNT_LAST);

  // One product term per cycle: sample * row factor, rescale, * column factor, rescale
  always_comb begin
    p1      = P1_W'(sample) * P1_W'(cx);
    s1      = p1 >>> COS_FRAC;
    p2      = P2_W'(s1) * P2_W'(cy);
    s2      = p2 >>> COS_FRAC;
    term    = ACC_W'(s2);
    acc_sum = (inner_first ? '0 : acc_q) + term;
  end

  // Normalisation on the completed sum
  always_comb begin
    sc0 = SC_W'(acc_sum);
    sc1 = (u_f == 3'd0) ? ((sc0 * SC_W'(INV_SQRT2_Q)) >>> COS_FRAC) : sc0;
    sc2 = (v_f == 3'd0) ? ((sc1 * SC_W'(INV_SQRT2_Q)) >>> COS_FRAC) : sc1;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = acc_sum;
      if (run_last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
    end
  end

  assign smp_idx = cnt_q[IDX_W-1:0];
  assign busy    = busy_q;
  assign finish  = run_last;
  assign res_we  = busy_q && inner_last;
  assign res_idx = cnt_q[CNT_W-1:IDX_W];
  assign res_val = OUT_W'(sc2 >>> POST_SHR);

endmodule

// File: rtl/fdct_regif.sv
module fdct_regif
  import fdct_pkg::*;
#(
  parameter int SAMP_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [1:0]               addr,
  input  logic [SAMP_W-1:0]        wdata,
  output logic [OUT_W-1:0]         rdata,
  input  logic                     busy,
  input  logic                     finish,
  input  logic                     res_we,
  input  logic [IDX_W-1:0]         res_idx,
  input  logic signed [OUT_W-1:0]  res_val,
  input  logic [IDX_W-1:0]         smp_idx,
  output logic signed [SAMP_W-1:0] sample,
  output logic                     start,
  output logic                     done
);

  logic signed [SAMP_W-1:0] in_mem  [BLK_SZ];
  logic signed [OUT_W-1:0]  out_mem [BLK_SZ];

  logic [IDX_W-1:0] push_q, push_d;
  logic [IDX_W-1:0] pop_q, pop_d;
  logic             done_q, done_d;
  logic [OUT_W-1:0] rdata_q, rdata_d;
  logic             push_en, pop_en, rd_any;

  assign start   = wr_en && (reg_sel_e'(addr) == REG_CMD) && wdata[0] && !busy;
  assign push_en = wr_en && (reg_sel_e'(addr) == REG_DIN) && !busy;
  assign pop_en  = rd_en && (reg_sel_e'(addr) == REG_DOUT) && !busy;
  assign rd_any  = rd_en;

  always_comb begin
    push_d = push_q;
    pop_d  = pop_q;
    done_d = done_q;
    if (start) begin
      push_d = '0;
      pop_d  = '0;
      done_d = 1'b0;
    end else begin
      if (push_en) push_d = push_q + 1'b1;
      if (pop_en)  pop_d  = pop_q + 1'b1;
      if (finish)  done_d = 1'b1;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_any) begin
      case (reg_sel_e'(addr))
        REG_DOUT: rdata_d = busy ? '0 : OUT_W'(out_mem[pop_q]);
        REG_STAT: rdata_d = OUT_W'({busy, done_q});
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q  <= '0;
      pop_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      push_q  <= push_d;
      pop_q   <= pop_d;
      done_q  <= done_d;
      if (rd_any) rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) in_mem[push_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (res_we) out_mem[res_idx] <= res_val;
  end

  assign sample = in_mem[smp_idx];
  assign rdata  = rdata_q;
  assign done   = done_q;

endmodule

// File: rtl/fdct_coproc.sv
module fdct_coproc
  import fdct_pkg::*;
#(
  parameter int SAMP_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [SAMP_W-1:0] wdata,
  output logic [OUT_W-1:0]  rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                     start, busy, finish, done, res_we;
  logic [IDX_W-1:0]         res_idx, smp_idx;
  logic signed [OUT_W-1:0]  res_val;
  logic signed [SAMP_W-1:0] sample;

  fdct_regif #(.SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .busy    (busy),
    .finish  (finish),
    .res_we  (res_we),
    .res_idx (res_idx),
    .res_val (res_val),
    .smp_idx (smp_idx),
    .sample  (sample),
    .start   (start),
    .done    (done)
  );

  fdct_engine #(.SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .sample  (sample),
    .smp_idx (smp_idx),
    .busy    (busy),
    .finish  (finish),
    .res_we  (res_we),
    .res_idx (res_idx),
    .res_val (res_val)
  );

endmodule

// File: rtl/fdct_coproc_chk.sv
module fdct_coproc_chk
  import fdct_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [OUT_W-1:0] rdata,
  input logic             start,
  input logic             busy,
  input logic             done
);

  localparam int RUN_W = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_CYC);

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              run_cnt <= '0;
    else if (start)                          run_cnt <= '0;
    else if (busy && (run_cnt != RUN_FULL))  run_cnt <= run_cnt + 1'b1;
  end

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RUN_FULL));

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < RUN_FULL));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  assert_dout_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 2'd1) && busy) |=> (rdata == '0));

  assert_stat_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 2'd3)) |=> (rdata == OUT_W'({$past(busy), $past(done)})));

  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind fdct_coproc fdct_coproc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .rd_en (rd_en),
  .addr  (addr),
  .rdata (rdata),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/fdct_coproc_tb.sv
module fdct_coproc_tb_top;

  localparam int SAMP_W = 12;
  localparam int OUT_W  = 16;
  localparam logic [1:0] A_DIN  = 2'd0;
  localparam logic [1:0] A_DOUT = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic              rd_en;
  logic [1:0]        addr;
  logic [SAMP_W-1:0] wdata;
  logic [OUT_W-1:0]  rdata;

  int n_chk;
  int n_fail;
  int ctab [8][8];
  int smp  [64];
  int coef [64];

  fdct_coproc #(.SAMP_W(SAMP_W), .OUT_W(OUT_W)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op_wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = SAMP_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic op_rd(input logic [1:0] a, output int q);
    rd_en = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = int'($signed(rdata));
  endtask

  // Behavioural reference for R5, R6, R7
  task automatic model_run();
    for (int u = 0; u < 8; u++) begin
      for (int v = 0; v < 8; v++) begin
        int acc;
        acc = 0;
        for (int x = 0; x < 8; x++) begin
          for (int y = 0; y < 8; y++) begin
            int t;
            t = (smp[x*8+y] * ctab[x][u]) >>> 6;
            t = (t * ctab[y][v]) >>> 6;
            acc += t;
          end
        end
        if (u == 0) acc = (acc * 45) >>> 6;
        if (v == 0) acc = (acc * 45) >>> 6;
        coef[u*8+v] = acc >>> 2;
      end
    end
  endtask

  task automatic push_all();
    for (int i = 0; i < 64; i++) op_wr(A_DIN, smp[i]);
  endtask

  // Poll status; count reads that report busy, then check the final status word
  task automatic wait_done(input int exp_busy, input string tag);
    int q;
    int nb;
    nb = 0;
    op_rd(A_STAT, q);
    while (q == 2 && nb < 6000) begin
      nb++;
      op_rd(A_STAT, q);
    end
    check({tag, " R4 busy length"}, nb, exp_busy);
    check({tag, " R4 done status"}, q, 1);
  endtask

  task automatic pop_all(input string tag);
    int q;
    for (int i = 0; i < 64; i++) begin
      op_rd(A_DOUT, q);
      check({tag, " R6 R7 R8 coefficient"}, q, coef[i]);
    end
  endtask

  initial begin
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 8; f++) begin
        real r;
        r = 64.0 * $cos((2.0 * p + 1.0) * f * 3.14159265358979 / 16.0);
        ctab[p][f] = int'($floor(r + 0.5));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int q;
    int seed;
    int extra;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    op_rd(A_STAT, q);  check("R4 reset status", q, 0);
    op_rd(A_DIN, q);   check("R1 data-in read", q, 0);

    // Ramp block
    for (int i = 0; i < 64; i++) smp[i] = i * 30 - 960;
    model_run();
    push_all();
    op_wr(A_CMD, 1);
    wait_done(4096, "ramp");
    pop_all("ramp");

    // Extreme checkerboard: largest magnitudes for R6 accumulator range
    for (int i = 0; i < 64; i++) smp[i] = (((i / 8) + (i % 8)) % 2 == 1) ? -2048 : 2047;
    model_run();
    push_all();
    op_wr(A_CMD, 1);
    wait_done(4096, "checker");
    pop_all("checker");

    // Flat negative block: energy only at (0,0), both R7 scalings
    for (int i = 0; i < 64; i++) smp[i] = -2048;
    model_run();
    push_all();
    op_wr(A_CMD, 1);
    wait_done(4096, "flat");
    pop_all("flat");

    // Pseudo-random block with a 65th write replacing sample 0 (R2)
    seed = 12345;
    for (int i = 0; i < 64; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      smp[i] = ((seed >>> 8) % 4096) - 2048;
    end
    push_all();
    extra = 1777;
    op_wr(A_DIN, extra);
    smp[0] = extra;
    model_run();
    op_wr(A_CMD, 1);
    wait_done(4096, "R2 wrap");
    pop_all("R2 wrap");
    op_rd(A_DOUT, q);  check("R8 pop wrap to index 0", q, coef[0]);

    // Command with bit 0 clear is ignored; command address reads 0
    op_wr(A_CMD, 2);
    op_rd(A_STAT, q);  check("R3 bit0 clear ignored", q, 1);
    op_rd(A_CMD, q);   check("R1 command read", q, 0);

    // Rerun on retained block with traffic during busy: 6 one-cycle accesses
    op_wr(A_CMD, 1);
    op_wr(A_DIN, 5);
    op_wr(A_DIN, -7);
    op_wr(A_DIN, 300);
    op_rd(A_DOUT, q);  check("R10 data-out read while busy", q, 0);
    op_rd(A_DOUT, q);  check("R10 second read while busy", q, 0);
    op_wr(A_CMD, 1);
    wait_done(4090, "R3 R9 busy traffic");
    pop_all("R9 R10 retained block");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule